// File: doc/BRIEF.md
# Selectable CRC Engine on a Byte Register Bus

This block computes a running cyclic redundancy check over bytes that software writes one at a time through a small byte-wide register bus. A control register chooses one of three generator polynomials and the bit order. It can also zero the result. Each byte written to the data port is folded into a 16-bit result within the same clock. The result can be read back as two bytes, and it can be preset by writing those two bytes directly.

The polynomials are x^8+x^2+x+1 (8-bit), x^16+x^15+x^2+1 and x^16+x^12+x^5+1 (both 16-bit). In MSB-first order each byte is consumed from bit 7 down, and the register shifts toward its high end. In LSB-first order each byte is consumed from bit 0 up, with the mirrored polynomial and the register shifting toward its low end. In both orders the register starts from its present contents, with no final inversion. To validate a message, the receiver runs the same setting over the message followed by its CRC bytes, sent in the order that setting implies, and expects a zero result.

Top module: `crc_regbus_engine`

## Requirements
- R1: After a synchronous reset the control value, the data register and both result bytes read as 0x00.
- R2: The control register is at offset 0. Its bit 2 (1 = MSB-first) and bits 1:0 (polynomial code) are stored and read back. Bits 7:3 always read as 0, and writes to bits 6:3 have no effect.
- R3: Writing the control register with bit 7 set forces the 16-bit result to 0x0000, while bits 2:0 are still taken from the same write.
- R4: The data register is at offset 1. A write stores the byte, which reads back unchanged, and folds it into the result by the next clock.
- R5: With MSB-first order and code 2'b10 (x^16+x^15+x^2+1) or 2'b11 (x^16+x^12+x^5+1), the result equals the bit-serial CRC from a zero start. The ASCII string "123456789" gives 0xFEE8 and 0x31C3 respectively.
- R6: With LSB-first order the mirrored polynomials are used. "123456789" gives 0xBB3D for code 2'b10 and 0x2189 for code 2'b11.
- R7: With code 2'b01 (x^8+x^2+x+1) the CRC sits in the low result byte (offset 3). The high byte (offset 2) is forced to 0 when this code is selected and stays 0: writes to offset 2 are ignored. MSB-first "123456789" gives 0xF4.
- R8: While the polynomial code is 2'b00, data writes leave the result unchanged.
- R9: If the CRC bytes are appended to the message, the result ends at 0x0000. The high byte goes first for MSB-first order, the low byte goes first for LSB-first order, and only the low byte is appended in 8-bit mode.
- R10: Offsets 2 and 3 write the high and low result bytes directly, and later data writes continue the CRC from that preset value.
- R11: Read data appears on rdata one clock after a cycle with rd_en high and holds its value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register offset |
| wr_en | input | 1 | Write strobe for the addressed register |
| rd_en | input | 1 | Read strobe; rdata loads on the next edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
Every polynomial is run in both bit orders over the nine-byte ASCII check string and over a short run of bytes with mixed bit patterns. The published check values tell a wrong tap set or a mirrored polynomial apart from a correct one, and a bench-side bit-serial model covers the remaining pairs. Appending the CRC bytes in transmit order separates a correct byte order from a swapped one, because only the correct order returns zero. Presetting the result, selecting code 00 and writing the high byte in 8-bit mode show whether state is held or lost where it must not change.

// File: rtl/crc_pkg.sv
package crc_pkg;

    localparam int BYTE_W = 8;
    localparam int CRC_W  = 16;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_DIN  = 2'd1;
    localparam logic [ADDR_W-1:0] OFS_RHI  = 2'd2;
    localparam logic [ADDR_W-1:0] OFS_RLO  = 2'd3;

    localparam int CLR_BIT   = 7;
    localparam int ORDER_BIT = 2;

    typedef enum logic [1:0] {
        POLY_NONE = 2'b00,
        POLY_8    = 2'b01,
        POLY_16A  = 2'b10,
        POLY_16B  = 2'b11
    } poly_e;

    typedef struct packed {
        logic  msb_first;
        poly_e poly;
    } ctrl_t;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_din;
        logic wr_hi;
        logic wr_lo;
    } strobe_t;

    // Generator taps without the leading term, aligned to bit 0
    function automatic logic [CRC_W-1:0] taps_normal(poly_e p);
        case (p)
            POLY_8:   return 16'h0007;
            POLY_16A: return 16'h8005;
            POLY_16B: return 16'h1021;
            default:  return 16'h0000;
        endcase
    endfunction

    function automatic int poly_width(poly_e p);
        return (p == POLY_8) ? BYTE_W : CRC_W;
    endfunction

    // Mirror the low w bits of the taps for LSB-first operation
    function automatic logic [CRC_W-1:0] taps_mirror(poly_e p);
        logic [CRC_W-1:0] src;
        logic [CRC_W-1:0] dst;
        int w;
        src = taps_normal(p);
        w   = poly_width(p);
        dst = '0;
        for (int i = 0; i < CRC_W; i++) begin
            if (i < w) dst[w-1-i] = src[i];
        end
        return dst;
    endfunction

    // One whole byte folded into the state, unrolled over the bits
    function automatic logic [CRC_W-1:0] fold_byte(
        logic [CRC_W-1:0]  cur,
        logic [BYTE_W-1:0] d,
        ctrl_t             c
    );
        logic [CRC_W-1:0] r;
        logic [CRC_W-1:0] tn;
        logic [CRC_W-1:0] tm;
        logic             fb;
        logic             narrow;
        narrow = (c.poly == POLY_8);
        tn = taps_normal(c.poly);
        tm = taps_mirror(c.poly);
        r  = narrow ? {8'h00, cur[7:0]} : cur;
        for (int i = 0; i < BYTE_W; i++) begin
            if (c.msb_first) begin
                if (narrow) begin
                    fb = r[7] ^ d[BYTE_W-1-i];
                    r  = {8'h00, r[6:0], 1'b0};
                end else begin
                    fb = r[15] ^ d[BYTE_W-1-i];
                    r  = {r[14:0], 1'b0};
                end
                if (fb) r = r ^ tn;
            end else begin
                fb = r[0] ^ d[i];
                r  = {1'b0, r[15:1]};
                if (fb) r = r ^ tm;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/crc_addr_decode.sv
module crc_addr_decode
    import crc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output strobe_t           stb
);
    always_comb begin
        stb         = '0;
        stb.wr_ctrl = wr_en && (addr == OFS_CTRL);
        stb.wr_din  = wr_en && (addr == OFS_DIN);
        stb.wr_hi   = wr_en && (addr == OFS_RHI);
        stb.wr_lo   = wr_en && (addr == OFS_RLO);
    end

    // R4: at most one register is targeted by a write
    always_comb begin
        one_target_chk: assert ($onehot0(stb));
    end
endmodule

// File: rtl/crc_byte_engine.sv
module crc_byte_engine
    import crc_pkg::*;
(
    input  logic [CRC_W-1:0]  cur,
    input  logic [BYTE_W-1:0] din,
    input  ctrl_t             ctrl,
    output logic [CRC_W-1:0]  nxt
);
    always_comb begin
        nxt = fold_byte(cur, din, ctrl);
    end
endmodule

// File: rtl/crc_regfile.sv
module crc_regfile
    import crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  strobe_t           stb,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CRC_W-1:0]  nxt,
    output ctrl_t             ctrl,
    output logic [BYTE_W-1:0] din_q,
    output logic [CRC_W-1:0]  result
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            din_q  <= '0;
            result <= '0;
        end else if (stb.wr_ctrl) begin
            ctrl.msb_first <= wdata[ORDER_BIT];
            ctrl.poly      <= poly_e'(wdata[1:0]);
            if (wdata[CLR_BIT]) begin
                result <= '0;
            end else if (poly_e'(wdata[1:0]) == POLY_8) begin
                result[15:8] <= '0;
            end
        end else if (stb.wr_din) begin
            din_q <= wdata;
            if (ctrl.poly != POLY_NONE) result <= nxt;
        end else if (stb.wr_hi) begin
            if (ctrl.poly != POLY_8) result[15:8] <= wdata;
        end else if (stb.wr_lo) begin
            result[7:0] <= wdata;
        end
    end

    // R3
    clr_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (stb.wr_ctrl && wdata[CLR_BIT]) |=> (result == '0));

    // R8
    rsvd_poly_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (stb.wr_din && ctrl.poly == POLY_NONE) |=> $stable(result));

    // R7
    narrow_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.poly == POLY_8) |-> (result[15:8] == 8'h00));

    // R4
    din_capture_chk: assert property (@(posedge clk) disable iff (rst)
        stb.wr_din |=> (din_q == $past(wdata)));
endmodule

// File: rtl/crc_regbus_engine.sv
module crc_regbus_engine
    import crc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  addr,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata
);
    strobe_t           stb;
    ctrl_t             ctrl;
    logic [BYTE_W-1:0] din_q;
    logic [CRC_W-1:0]  result;
    logic [CRC_W-1:0]  nxt;
    logic [BYTE_W-1:0] rd_mux;

    crc_addr_decode u_dec (
        .addr  (addr),
        .wr_en (wr_en),
        .stb   (stb)
    );

    crc_byte_engine u_eng (
        .cur  (result),
        .din  (wdata),
        .ctrl (ctrl),
        .nxt  (nxt)
    );

    crc_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .stb    (stb),
        .wdata  (wdata),
        .nxt    (nxt),
        .ctrl   (ctrl),
        .din_q  (din_q),
        .result (result)
    );

    always_comb begin
        case (addr)
            OFS_CTRL: rd_mux = {5'b00000, ctrl.msb_first, ctrl.poly};
            OFS_DIN:  rd_mux = din_q;
            OFS_RHI:  rd_mux = result[15:8];
            default:  rd_mux = result[7:0];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    // R2
    ctrl_rsvd_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == OFS_CTRL) |=> (rdata[7:3] == 5'b00000));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));
endmodule

// File: tb/test_crc_regbus_engine.sv
module test_crc_regbus_engine;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] addr;
    logic       wr_en;
    logic       rd_en;
    logic [7:0] wdata;
    logic [7:0] rdata;

    always #5 clk = ~clk;

    crc_regbus_engine i_crc_regbus_engine (
        .clk   (clk),
        .rst   (rst),
        .addr  (addr),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .wdata (wdata),
        .rdata (rdata)
    );

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    // bench-side model state
    logic [15:0] m_res;
    logic        m_msb;
    logic [1:0]  m_poly;
    logic [7:0]  m_din;

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] rev_n(input logic [15:0] v, input int w);
        logic [15:0] o = '0;
        for (int i = 0; i < w; i++) o[w-1-i] = v[i];
        return o;
    endfunction

    // plain bit-serial division, high-order bit first
    function automatic logic [15:0] serial_div(input logic [15:0] st, input logic [7:0] b,
                                               input int w, input logic [15:0] p);
        logic [15:0] s = st;
        logic [15:0] mask = (w == 8) ? 16'h00FF : 16'hFFFF;
        for (int k = 7; k >= 0; k--) begin
            logic top;
            top = s[w-1] ^ b[k];
            s = (s << 1) & mask;
            if (top) s = s ^ p;
        end
        return s;
    endfunction

    function automatic logic [15:0] ref_step(input logic [15:0] st, input logic [7:0] b,
                                             input logic msb, input logic [1:0] pc);
        int w;
        logic [15:0] p;
        if (pc == 2'b00) return st;
        w = (pc == 2'b01) ? 8 : 16;
        p = (pc == 2'b01) ? 16'h0007 : (pc == 2'b10) ? 16'h8005 : 16'h1021;
        if (msb) return serial_div(st, b, w, p);
        return rev_n(serial_div(rev_n(st, w), rev_n({8'h00, b}, 8)[7:0], w, p), w);
    endfunction

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic set_ctrl(input logic [7:0] v);
        bus_wr(2'd0, v);
        m_msb  = v[2];
        m_poly = v[1:0];
        if (v[7]) m_res = '0;
        else if (v[1:0] == 2'b01) m_res[15:8] = 8'h00;
    endtask

    task automatic put_byte(input logic [7:0] b);
        bus_wr(2'd1, b);
        m_din = b;
        m_res = ref_step(m_res, b, m_msb, m_poly);
    endtask

    task automatic put_hi(input logic [7:0] b);
        bus_wr(2'd2, b);
        if (m_poly != 2'b01) m_res[15:8] = b;
    endtask

    task automatic put_lo(input logic [7:0] b);
        bus_wr(2'd3, b);
        m_res[7:0] = b;
    endtask

    // driver: issue a read and push the expected byte
    task automatic bus_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        item_t it;
        it.exp = e; it.tag = tag;
        @(negedge clk);
        addr = a; rd_en = 1'b1; wr_en = 1'b0;
        sb_q.push_back(it);
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    task automatic rd_result(input logic [15:0] e, input string tag);
        bus_rd(2'd2, e[15:8], {tag, " hi"});
        bus_rd(2'd3, e[7:0], {tag, " lo"});
    endtask

    // monitor
    logic rd_seen = 1'b0;
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R11 unexpected read actual=%h expected=none", rdata);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check({8'h00, rdata}, {8'h00, it.exp}, it.tag);
            end
        end
    end

    task automatic run_case(input logic msb, input logic [1:0] pc,
                            input logic use_known, input logic [15:0] known, input string tag);
        logic [7:0] msg [9] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        logic [15:0] c;
        set_ctrl({1'b1, 4'b0000, msb, pc});
        foreach (msg[i]) put_byte(msg[i]);
        c = use_known ? known : m_res;
        rd_result(c, tag);
        // R9: append CRC in transmit order
        c = m_res;
        if (pc == 2'b01) put_byte(c[7:0]);
        else if (msb) begin put_byte(c[15:8]); put_byte(c[7:0]); end
        else begin put_byte(c[7:0]); put_byte(c[15:8]); end
        rd_result(16'h0000, "R9 residue");
    endtask

    initial begin
        rst = 1'b1; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wdata = '0;
        m_res = '0; m_msb = 1'b0; m_poly = 2'b00; m_din = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        bus_rd(2'd0, 8'h00, "R1 ctrl");
        bus_rd(2'd1, 8'h00, "R1 din");
        rd_result(16'h0000, "R1 result");

        // R2 reserved bits ignored
        set_ctrl(8'h7B);
        bus_rd(2'd0, 8'h03, "R2 ctrl readback");
        set_ctrl(8'h05);
        bus_rd(2'd0, 8'h05, "R2 ctrl order");

        // R10 preset, R8 reserved code holds
        set_ctrl(8'h00);
        put_hi(8'hAB); put_lo(8'hCD);
        rd_result(16'hABCD, "R10 preset");
        put_byte(8'h5A);
        rd_result(16'hABCD, "R8 reserved code");
        bus_rd(2'd1, 8'h5A, "R4 din readback");

        // R10 continue from preset
        set_ctrl(8'h07);
        put_hi(8'h12); put_lo(8'h34);
        put_byte(8'hF0); put_byte(8'h0F);
        rd_result(m_res, "R10 continue");

        // R3 clear, control bits still taken
        set_ctrl(8'h82);
        rd_result(16'h0000, "R3 clear");
        bus_rd(2'd0, 8'h02, "R3 ctrl");

        // R5/R6/R7 check strings
        run_case(1'b1, 2'b10, 1'b1, 16'hFEE8, "R5 poly10 msb");
        run_case(1'b1, 2'b11, 1'b1, 16'h31C3, "R5 poly11 msb");
        run_case(1'b0, 2'b10, 1'b1, 16'hBB3D, "R6 poly10 lsb");
        run_case(1'b0, 2'b11, 1'b1, 16'h2189, "R6 poly11 lsb");
        run_case(1'b1, 2'b01, 1'b1, 16'h00F4, "R7 poly01 msb");
        run_case(1'b0, 2'b01, 1'b0, 16'h0000, "R7 poly01 lsb");

        // R5/R6 mixed patterns against model
        for (int o = 0; o < 2; o++) begin
            for (int p = 1; p < 4; p++) begin
                set_ctrl({1'b1, 4'b0000, o[0], p[1:0]});
                put_byte(8'h00); put_byte(8'hFF); put_byte(8'h80);
                put_byte(8'h01); put_byte(8'hA5);
                rd_result(m_res, o ? "R5 pattern" : "R6 pattern");
            end
        end

        // R7 high byte forced zero and ignored
        set_ctrl(8'h02);
        put_hi(8'h99); put_lo(8'h11);
        set_ctrl(8'h01);
        rd_result({8'h00, 8'h11}, "R7 switch clears hi");
        put_hi(8'hFF);
        rd_result(m_res, "R7 hi write ignored");

        // R11 hold while rd_en low
        bus_rd(2'd3, m_res[7:0], "R11 read");
        repeat (2) @(posedge clk);
        @(negedge clk);
        addr = 2'd0;
        @(negedge clk);
        check({8'h00, rdata}, {8'h00, m_res[7:0]}, "R11 hold");

        repeat (3) @(posedge clk);
        if (sb_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R11 pending reads actual=%0d expected=0", sb_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule